// File: doc/BRIEF.md
# I2C Master High-Speed Entry Sequencer

This block produces the bus timing of an I2C master and handles entry into high-speed operation. It drives two open-drain enables: a 1 on `scl_oe` or `sda_oe` pulls that line low, and a 0 releases it. A prescaler divides the system clock into ticks. Each tick lasts 2 × (1 + P) clocks, where P is the selected timer period. Each SCL bit is made of a low phase and a high phase, each a fixed number of ticks long. At the slow rate the phases are 6 low and 4 high ticks. In high-speed operation they are 2 low and 1 high tick. One SCL period is therefore 2 × (1 + P) × (low + high) clocks.

A start request with `hs_en` set runs this sequence:
- a START condition and a master code byte `0000_1mmm` at the slow rate;
- a ninth slot in which no acknowledge is expected;
- a repeated START, with the timing switched to the high-speed ratio and period;
- the address byte and its acknowledge slot;
- a STOP.

`done` pulses when the transfer ends, and the timing returns to the slow rate. When `hs_en` is clear, the sequence is only START, address byte, acknowledge slot and STOP, all at the slow rate.

Top module: `i2c_hs_entry_master`

## Requirements
- R1: After reset, `scl_oe`, `sda_oe`, `busy`, `hs_active`, `done`, `unexp_ack` and `addr_nack` are all 0.
- R2: At the slow rate with period P = `norm_prd`, SCL releases are spaced 20 × (P + 1) clocks apart, and each released (high) phase lasts 8 × (P + 1) clocks.
- R3: In high-speed operation, SCL releases are spaced 6 × (Q + 1) clocks apart and each high phase lasts 2 × (Q + 1) clocks, where Q is the period in use.
- R4: In high-speed operation, Q = `hs_prd` when `hs_prd_sel` is 1 and Q = `norm_prd` when `hs_prd_sel` is 0.
- R5: With `hs_en` = 1, the first byte is `{4'b0000, 1'b1, mcode}`, sent MSB first at the slow rate, followed by a ninth slot in which SDA is released.
- R6: A low SDA sampled in the master code's ninth slot sets `unexp_ack`, and the transfer continues unchanged. A high SDA there is the normal case and sets no status.
- R7: After the master code's ninth slot, the block sends a repeated START: SCL is released with SDA released, then SDA is pulled low while SCL stays high. `hs_active` rises at the end of that ninth slot. The address byte, MSB first, then uses the high-speed timing.
- R8: Within a transfer, SDA changes only while SCL is held low. The exceptions are the SDA edges that form START, repeated START and STOP.
- R9: SDA is sampled at the moment SCL is released for the address ninth slot. A high level there sets `addr_nack`.
- R10: STOP pulls SDA low while SCL is released and then releases SDA. `done` is then a single-cycle pulse, `busy` and `hs_active` return to 0, and the next transfer starts at the slow rate.
- R11: With `hs_en` = 0, no master code is sent. The address byte follows the START directly, at the slow rate, and `hs_active` stays 0.
- R12: A `start` asserted while `busy` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| norm_prd | input | PRD_W | Timer period for the slow rate |
| hs_prd | input | PRD_W | Timer period for high-speed operation |
| hs_prd_sel | input | 1 | Use `hs_prd` during high-speed operation |
| hs_en | input | 1 | Prefix the transfer with the master code and switch to high speed |
| start | input | 1 | Start request, accepted when idle |
| mcode | input | 3 | Low three bits of the master code |
| addr | input | 8 | Address byte sent after entry |
| sda_in | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| busy | output | 1 | Transfer in progress |
| hs_active | output | 1 | High-speed timing in use |
| done | output | 1 | One-cycle pulse after STOP |
| unexp_ack | output | 1 | Master code slot was acknowledged |
| addr_nack | output | 1 | Address slot was not acknowledged |

## Verification
Two kinds of internal fault show up at the ports in different ways.

A wrong phase length or period selection inside the sequencer shows directly on the next SCL release: the spacing between two releases and the high-phase width then differ from the ratio formula, within one bit time. A switch to high speed at the wrong moment shows as the wrong spacing on the first address bit, or as `hs_active` being seen during the master code. These are caught before the STOP.

A wrong bit counter or shift register corrupts the bit sequence seen at each SCL release, or drops the repeated START, and this is visible within the affected byte. A wrong sample point or status latch shows only in `unexp_ack` and `addr_nack` once `done` pulses.

// File: rtl/i2c_hs_pkg.sv
package i2c_hs_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_START,
      S_BLO,
      S_BHI,
      S_RLO,
      S_RHI,
      S_RHOLD,
      S_PLO,
      S_PHI,
      S_PREL
   } seq_st_t;

   // States in which SCL is held low by the master
   function automatic logic st_scl_low(seq_st_t s);
      return (s == S_BLO) || (s == S_RLO) || (s == S_PLO);
   endfunction

endpackage

// File: rtl/i2c_hs_tick.sv
module i2c_hs_tick #(
   parameter int PRD_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [PRD_W-1:0] prd,
   output logic             tick
);
   localparam int CNT_W = PRD_W + 1;

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] reload;

   // reload = 2*prd + 1 gives 2*(prd+1) clocks per tick
   assign reload = {prd, 1'b1};
   assign tick   = run && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!run || cnt == '0)
         cnt <= reload;
      else
         cnt <= cnt - 1'b1;
   end

   initial begin
      assert (PRD_W >= 1) else $error("PRD_W must be at least 1");
   end

   // R2/R3: ticks are never adjacent, so every phase spans whole ticks
   a_r2_tick_gap : assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

endmodule

// File: rtl/i2c_hs_seq.sv
module i2c_hs_seq
   import i2c_hs_pkg::*;
#(
   parameter int LP_STD = 6,
   parameter int HP_STD = 4,
   parameter int LP_HS  = 2,
   parameter int HP_HS  = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       hs_en,
   input  logic [2:0] mcode,
   input  logic [7:0] addr,
   input  logic       tick,
   input  logic       sda_in,
   output logic       scl_oe,
   output logic       sda_oe,
   output logic       busy,
   output logic       hs_active,
   output logic       hs_next,
   output logic       done,
   output logic       unexp_ack,
   output logic       addr_nack
);
   localparam int BYTE_W  = 8;
   localparam int IDX_W   = $clog2(BYTE_W + 1);
   localparam int MAX_A   = (LP_STD > HP_STD) ? LP_STD : HP_STD;
   localparam int MAX_B   = (LP_HS > HP_HS) ? LP_HS : HP_HS;
   localparam int SEG_MAX = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int SEG_W   = $clog2(SEG_MAX + 1);
   localparam logic [IDX_W-1:0] ACK_IDX = IDX_W'(BYTE_W);

   seq_st_t          st, st_n;
   logic [SEG_W-1:0] seg, seg_len;
   logic [IDX_W-1:0] idx;
   logic [7:0]       shreg, addr_q;
   logic             mc_ph, hs_q, sda_q, sda_tgt, lo, seg_end;
   logic             unexp_q, nack_q;

   assign lo      = st_scl_low(st);
   assign seg_len = lo ? (hs_q ? SEG_W'(LP_HS) : SEG_W'(LP_STD))
                       : (hs_q ? SEG_W'(HP_HS) : SEG_W'(HP_STD));
   assign seg_end = tick && (seg == seg_len - 1'b1);

   always_comb begin
      st_n = st;
      case (st)
         S_IDLE:  if (start) st_n = S_START;
         S_START: if (seg_end) st_n = S_BLO;
         S_BLO:   if (seg_end) st_n = S_BHI;
         S_BHI:   if (seg_end) begin
                     if (idx != ACK_IDX) st_n = S_BLO;
                     else if (mc_ph)     st_n = S_RLO;
                     else                st_n = S_PLO;
                  end
         S_RLO:   if (seg_end) st_n = S_RHI;
         S_RHI:   if (seg_end) st_n = S_RHOLD;
         S_RHOLD: if (seg_end) st_n = S_BLO;
         S_PLO:   if (seg_end) st_n = S_PHI;
         S_PHI:   if (seg_end) st_n = S_PREL;
         S_PREL:  if (seg_end) st_n = S_IDLE;
         default: st_n = S_IDLE;
      endcase
   end

   always_comb begin
      hs_next = hs_q;
      if (st == S_BHI && seg_end && idx == ACK_IDX && mc_ph) hs_next = 1'b1;
      else if (st == S_PREL && seg_end)                      hs_next = 1'b0;
   end

   always_comb begin
      case (st)
         S_START, S_RHOLD, S_PLO, S_PHI: sda_tgt = 1'b1;
         S_BLO, S_BHI: sda_tgt = (idx != ACK_IDX) ? ~shreg[7] : 1'b0;
         default:      sda_tgt = 1'b0;
      endcase
   end

   // First tick of a low phase keeps the previous SDA level
   assign sda_oe    = (lo && seg == '0) ? sda_q : sda_tgt;
   assign scl_oe    = lo;
   assign busy      = (st != S_IDLE);
   assign hs_active = hs_q;
   assign unexp_ack = unexp_q;
   assign addr_nack = nack_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= S_IDLE;
         seg     <= '0;
         idx     <= '0;
         shreg   <= '0;
         addr_q  <= '0;
         mc_ph   <= 1'b0;
         hs_q    <= 1'b0;
         sda_q   <= 1'b0;
         done    <= 1'b0;
         unexp_q <= 1'b0;
         nack_q  <= 1'b0;
      end else begin
         st    <= st_n;
         hs_q  <= hs_next;
         sda_q <= sda_oe;
         done  <= (st == S_PREL) && seg_end;
         if (st == S_IDLE) begin
            seg <= '0;
            if (start) begin
               shreg   <= hs_en ? {4'b0000, 1'b1, mcode} : addr;
               addr_q  <= addr;
               mc_ph   <= hs_en;
               idx     <= '0;
               unexp_q <= 1'b0;
               nack_q  <= 1'b0;
            end
         end else if (seg_end) begin
            seg <= '0;
         end else if (tick) begin
            seg <= seg + 1'b1;
         end
         if (st == S_BLO && seg_end && idx == ACK_IDX) begin
            if (mc_ph && !sda_in)  unexp_q <= 1'b1;
            if (!mc_ph && sda_in)  nack_q  <= 1'b1;
         end
         if (st == S_BHI && seg_end) begin
            if (idx != ACK_IDX) begin
               idx   <= idx + 1'b1;
               shreg <= {shreg[6:0], 1'b0};
            end else if (mc_ph) begin
               mc_ph <= 1'b0;
               shreg <= addr_q;
               idx   <= '0;
            end
         end
      end
   end

   initial begin
      assert (LP_STD >= 2 && LP_HS >= 2) else $error("low phases need two ticks");
      assert (HP_STD >= 1 && HP_HS >= 1) else $error("high phases need a tick");
   end

   a_r8_sda_moves_low : assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe != $past(sda_oe)) |->
         ((scl_oe && $past(scl_oe)) || st == S_START || st == S_RHOLD || st == S_PREL));

   a_r10_done_single : assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r7_hs_at_restart : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_active) |-> (st == S_RLO));

   a_r6_unexp_in_mcode : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unexp_ack) |-> (busy && !hs_active));

   a_r10_idle_slow : assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !hs_active);

   a_r12_start_ignored : assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !done) |=> $stable(addr_q));

endmodule

// File: rtl/i2c_hs_entry_master.sv
module i2c_hs_entry_master #(
   parameter int PRD_W  = 8,
   parameter int LP_STD = 6,
   parameter int HP_STD = 4,
   parameter int LP_HS  = 2,
   parameter int HP_HS  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PRD_W-1:0] norm_prd,
   input  logic [PRD_W-1:0] hs_prd,
   input  logic             hs_prd_sel,
   input  logic             hs_en,
   input  logic             start,
   input  logic [2:0]       mcode,
   input  logic [7:0]       addr,
   input  logic             sda_in,
   output logic             scl_oe,
   output logic             sda_oe,
   output logic             busy,
   output logic             hs_active,
   output logic             done,
   output logic             unexp_ack,
   output logic             addr_nack
);
   logic             tick, hs_next;
   logic [PRD_W-1:0] prd_use;

   // Period for the tick that follows: the high-speed value only when selected
   assign prd_use = (hs_next && hs_prd_sel) ? hs_prd : norm_prd;

   i2c_hs_tick #(.PRD_W(PRD_W)) i_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (busy),
      .prd   (prd_use),
      .tick  (tick)
   );

   i2c_hs_seq #(
      .LP_STD (LP_STD),
      .HP_STD (HP_STD),
      .LP_HS  (LP_HS),
      .HP_HS  (HP_HS)
   ) i_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .hs_en     (hs_en),
      .mcode     (mcode),
      .addr      (addr),
      .tick      (tick),
      .sda_in    (sda_in),
      .scl_oe    (scl_oe),
      .sda_oe    (sda_oe),
      .busy      (busy),
      .hs_active (hs_active),
      .hs_next   (hs_next),
      .done      (done),
      .unexp_ack (unexp_ack),
      .addr_nack (addr_nack)
   );

   a_r4_slow_when_idle : assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (prd_use == norm_prd));

endmodule

// File: tb/test_i2c_hs_entry_master.sv
`timescale 1ns/1ps
module test_i2c_hs_entry_master;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] norm_prd = 8'd3, hs_prd = 8'd1;
   logic       hs_prd_sel = 1'b1, hs_en = 1'b0, start = 1'b0;
   logic [2:0] mcode = 3'd0;
   logic [7:0] addr = 8'd0;
   logic       pull_mc = 1'b0, pull_ad = 1'b0;
   logic       scl_oe, sda_oe, busy, hs_active, done, unexp_ack, addr_nack;
   logic       sda_in;

   int n_chk = 0, n_fail = 0;
   int cyc = 0;
   logic mon_on = 1'b0, p_scl = 1'b0, p_sda = 1'b0;
   int rel_t[32], pull_t[32], rel_b[32], rel_hs[32];
   int nrel, npull, nsda_hi, ndone, nhs;

   always #5 clk = ~clk;

   // Slave model: ack level follows the phase being transferred
   assign sda_in = ~(sda_oe | (hs_active ? pull_ad : pull_mc));

   i2c_hs_entry_master i_i2c_hs_entry_master (
      .clk(clk), .rst_n(rst_n), .norm_prd(norm_prd), .hs_prd(hs_prd),
      .hs_prd_sel(hs_prd_sel), .hs_en(hs_en), .start(start), .mcode(mcode),
      .addr(addr), .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe),
      .busy(busy), .hs_active(hs_active), .done(done),
      .unexp_ack(unexp_ack), .addr_nack(addr_nack));

   always @(negedge clk) begin
      cyc++;
      if (mon_on) begin
         if (!scl_oe && p_scl && nrel < 32) begin
            rel_t[nrel] = cyc; rel_b[nrel] = int'(!sda_oe); rel_hs[nrel] = int'(hs_active);
            nrel++;
         end
         if (scl_oe && !p_scl && npull < 32) begin
            pull_t[npull] = cyc; npull++;
         end
         if (sda_oe != p_sda && !scl_oe && !p_scl) nsda_hi++;
         if (done) ndone++;
         if (hs_active) nhs++;
      end
      p_scl = scl_oe;
      p_sda = sda_oe;
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic clear_mon();
      nrel = 0; npull = 0; nsda_hi = 0; ndone = 0; nhs = 0;
      mon_on = 1'b1;
   endtask

   task automatic pulse_start();
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
   endtask

   task automatic wait_done();
      while (ndone == 0) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   // Compare released-SCL bit levels from index base against a byte + ack slot
   function automatic int byte_mism(input int base, input logic [7:0] b);
      int m = 0;
      for (int i = 0; i < 8; i++) if (rel_b[base + i] != int'(b[7 - i])) m++;
      if (rel_b[base + 8] != 1) m++;
      return m;
   endfunction

   task automatic t_reset();
      chk("R1 scl_oe", int'(scl_oe), 0);
      chk("R1 sda_oe", int'(sda_oe), 0);
      chk("R1 busy/hs_active/done", int'({busy, hs_active, done}), 0);
      chk("R1 status", int'({unexp_ack, addr_nack}), 0);
   endtask

   task automatic t_hs_entry();
      norm_prd = 8'd3; hs_prd = 8'd1; hs_prd_sel = 1'b1; hs_en = 1'b1;
      mcode = 3'b101; addr = 8'hA6; pull_mc = 1'b0; pull_ad = 1'b1;
      clear_mon();
      pulse_start();
      wait_done();
      chk("R5 release count", nrel, 20);
      chk("R5 master code bits", byte_mism(0, 8'b0000_1101), 0);
      chk("R2 slow period", rel_t[1] - rel_t[0], 80);
      chk("R2 slow high", pull_t[1] - rel_t[0], 32);
      chk("R7 restart release SDA high", rel_b[9], 1);
      chk("R7 hs off during code", rel_hs[8], 0);
      chk("R7 hs on for address", rel_hs[10], 1);
      chk("R7 address bits", byte_mism(10, 8'hA6), 0);
      chk("R3 hs period", rel_t[11] - rel_t[10], 12);
      chk("R3 hs high", pull_t[11] - rel_t[10], 4);
      chk("R10 stop release SDA low", rel_b[19], 0);
      chk("R8 SDA edges with SCL high", nsda_hi, 3);
      chk("R6 no unexpected ack", int'(unexp_ack), 0);
      chk("R9 address acked", int'(addr_nack), 0);
      chk("R10 single done", ndone, 1);
      chk("R10 idle after", int'({busy, hs_active}), 0);
   endtask

   task automatic t_hs_normprd();
      norm_prd = 8'd2; hs_prd = 8'd1; hs_prd_sel = 1'b0; hs_en = 1'b1;
      mcode = 3'b010; addr = 8'h3C; pull_mc = 1'b1; pull_ad = 1'b0;
      clear_mon();
      pulse_start();
      wait_done();
      chk("R10 back to slow period", rel_t[1] - rel_t[0], 60);
      chk("R4 hs uses norm_prd", rel_t[11] - rel_t[10], 18);
      chk("R4 hs high norm_prd", pull_t[11] - rel_t[10], 6);
      chk("R6 unexpected ack flagged", int'(unexp_ack), 1);
      chk("R6 transfer continues", byte_mism(10, 8'h3C), 0);
      chk("R9 address nack", int'(addr_nack), 1);
   endtask

   task automatic t_slow_only();
      norm_prd = 8'h13; hs_en = 1'b0; addr = 8'h5B; pull_mc = 1'b1; pull_ad = 1'b0;
      clear_mon();
      pulse_start();
      wait_done();
      chk("R11 release count", nrel, 10);
      chk("R11 address bits", byte_mism(0, 8'h5B), 0);
      chk("R2 period 0x13", rel_t[1] - rel_t[0], 400);
      chk("R2 high 0x13", pull_t[1] - rel_t[0], 160);
      chk("R11 hs never active", nhs, 0);
      chk("R8 SDA edges slow", nsda_hi, 2);
      chk("R9 slow ack seen", int'(addr_nack), 0);
   endtask

   task automatic t_busy_start();
      norm_prd = 8'd0; hs_en = 1'b0; addr = 8'hC3; pull_mc = 1'b1;
      clear_mon();
      pulse_start();
      repeat (30) @(negedge clk);
      addr = 8'h18; hs_en = 1'b1;
      pulse_start();
      wait_done();
      repeat (40) @(negedge clk);
      chk("R12 bits unchanged", byte_mism(0, 8'hC3), 0);
      chk("R12 one transfer", ndone, 1);
      chk("R12 idle", int'(busy), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_hs_entry();
      t_hs_normprd();
      t_slow_only();
      t_busy_start();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule